// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address of every beat of one SDRAM burst. A memory model or controller pulses a start input together with the first column, a three-bit burst length code and an ordering select. The block then presents one column per clock together with a per-beat valid flag. It raises a one-cycle done flag once the burst has ended.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block of columns. They run either in sequential order or in interleaved (XOR) order. A full-page burst walks every column of the 256-column row in rising order and wraps from the top column back to zero. It keeps running until a terminate pulse arrives. A terminate pulse also cuts a fixed burst short. A new start pulse during a burst drops the running burst and begins the new one at once.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the block clears itself: beat_vld_o = 0, done_o = 0 and col_o = 0 from the next cycle on. col_o reads 0 whenever beat_vld_o is 0.
- R2: start_i is sampled at a rising edge together with start_col_i, bl_code_i and ilv_i. In the following cycle beat_vld_o = 1 and col_o = start_col_i, which is beat 0. Each later rising edge moves to the next beat.
- R3: The length code bl_code_i means 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. The unused codes 3'b100, 3'b101 and 3'b110 behave as 1 beat. A fixed burst that is neither stopped nor restarted shows exactly that many cycles with beat_vld_o = 1.
- R4: With ilv_i = 0, a fixed burst of length L starting at column S gives, at beat i, the column whose bits above log2(L) equal those of S and whose low log2(L) bits equal (S + i) mod L.
- R5: With ilv_i = 1, a fixed burst of length L gives, at beat i, S with its low log2(L) bits XORed by i. The bits above stay as in S.
- R6: A full-page burst gives (S + i) mod 256 at beat i, so it wraps from 255 to 0. It ignores ilv_i and runs for as many beats as it takes until it is stopped, including more than 256 beats.
- R7: stop_i high at a rising edge while a burst is active and start_i is low ends the burst. In the next cycle beat_vld_o = 0.
- R8: When a burst ends, whether by its last fixed beat or by stop_i, done_o is 1 for exactly the one cycle after the final beat. done_o and beat_vld_o are never 1 together.
- R9: start_i high at a rising edge while a burst is active abandons that burst without a done_o pulse. The new beat 0 appears in the next cycle. start_i takes priority over stop_i at the same edge.
- R10: stop_i high while no burst is active has no effect. beat_vld_o and done_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a burst with the parameters below |
| stop_i | input | 1 | Terminates the active burst |
| start_col_i | input | 8 | First column of the burst |
| bl_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| col_o | output | 8 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench uses start columns whose low bits are not aligned. A design that carried into the upper bits, or that summed in place of the XOR, gives a column outside the aligned block at the wrap beat. A full-page burst is started at column 254 with interleave selected and left running past 256 beats. This exposes a design that stops at a fixed count, that wraps wrongly, or that lets the ordering select affect page mode. Termination, restart in mid-burst, start and stop at the same edge, stop while idle and the unused length codes are each driven. A design that pulsed done for an abandoned burst, or that let stop override start, shows the wrong valid or done cycle.

// File: rtl/bcs_pkg.sv
// Shared constants for the burst column sequencer.
// Assumes: a column address of COL_W_DEF bits, fixed bursts up to 2**FIX_LOG2 beats.
package bcs_pkg;
    localparam int COL_W_DEF = 8;
    localparam int FIX_LOG2  = 3;
    localparam int CODE_W    = 3;

    // length codes that the decoder recognises
    localparam logic [CODE_W-1:0] LEN_1    = 3'b000;
    localparam logic [CODE_W-1:0] LEN_2    = 3'b001;
    localparam logic [CODE_W-1:0] LEN_4    = 3'b010;
    localparam logic [CODE_W-1:0] LEN_8    = 3'b011;
    localparam logic [CODE_W-1:0] LEN_PAGE = 3'b111;
endpackage

// File: rtl/bcs_len_decode.sv
// Turns the burst length code into a wrap mask over the low column bits and a page flag.
// Assumes: unused codes behave as a single beat (mask of zero).
module bcs_len_decode #(
    parameter int COL_W  = bcs_pkg::COL_W_DEF,
    parameter int CODE_W = bcs_pkg::CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o
);
    import bcs_pkg::*;

    // purpose: map each code to the mask of column bits that take part in wrapping
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        case (code_i)
            LEN_1:    mask_o = '0;
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                page_o = 1'b1;
            end
            default:  mask_o = '0;
        endcase
    end
endmodule

// File: rtl/bcs_beat_ctrl.sv
// Tracks whether a burst is active, counts its beats and pulses done at its end.
// Assumes: mask_i and page_i describe the burst in progress; start wins over stop.
module bcs_beat_ctrl #(
    parameter int COL_W = bcs_pkg::COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic             done_o
);
    logic last_beat;

    // purpose: flag the final beat of a fixed-length burst
    always_comb last_beat = active_o && !page_i && (cnt_o == mask_i);

    // purpose: advance the beat counter and the active and done state each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            done_o   <= 1'b0;
        end else if (start_i) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
            done_o   <= 1'b0;
        end else if (active_o && (stop_i || last_beat)) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            done_o   <= 1'b1;
        end else begin
            done_o <= 1'b0;
            if (active_o) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/bcs_col_gen.sv
// Forms the column of the current beat from the base column and the beat index.
// Assumes: mask marks the wrapping low bits; ilv_i is already cleared for page bursts.
module bcs_col_gen #(
    parameter int COL_W = bcs_pkg::COL_W_DEF
) (
    input  logic             active_i,
    input  logic             ilv_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] cnt_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum_col;
    logic [COL_W-1:0] xor_col;

    // purpose: candidate low bits for both orderings
    always_comb begin
        sum_col = base_i + cnt_i;
        xor_col = base_i ^ cnt_i;
    end

    // per bit: held from the base, or taken from the chosen ordering
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        // purpose: select the source of column bit b
        always_comb begin
            if (!active_i)      col_o[b] = 1'b0;
            else if (!mask_i[b]) col_o[b] = base_i[b];
            else if (ilv_i)     col_o[b] = xor_col[b];
            else                col_o[b] = sum_col[b];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
// Top of the burst column sequencer: latches the burst setup on start and drives
// one column per clock with valid and done flags.
// Assumes: inputs synchronous to clk; reset synchronous and active low.
module burst_col_seq #(
    parameter int COL_W  = bcs_pkg::COL_W_DEF,
    parameter int CODE_W = bcs_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  col_o,
    output logic              beat_vld_o,
    output logic              done_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             page_q;
    logic             ilv_q;
    logic             active;
    logic [COL_W-1:0] cnt;

    bcs_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) u_dec (
        .code_i (bl_code_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    // purpose: capture the burst setup when a burst begins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            mask_q <= dec_mask;
            page_q <= dec_page;
            ilv_q  <= ilv_i && !dec_page;
        end
    end

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .mask_i   (mask_q),
        .page_i   (page_q),
        .active_o (active),
        .cnt_o    (cnt),
        .done_o   (done_o)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .active_i (active),
        .ilv_i    (ilv_q),
        .base_i   (base_q),
        .mask_i   (mask_q),
        .cnt_i    (cnt),
        .col_o    (col_o)
    );

    // purpose: a beat is valid exactly while a burst is active
    always_comb beat_vld_o = active;
endmodule

// File: rtl/bcs_checker.sv
// Assertion checker for burst_col_seq, bound to every instance of it.
// Assumes: the same parameters as the bound instance.
module bcs_checker #(
    parameter int COL_W  = bcs_pkg::COL_W_DEF,
    parameter int CODE_W = bcs_pkg::CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] bl_code_i,
    input logic [COL_W-1:0]  col_o,
    input logic              beat_vld_o,
    input logic              done_o
);
    localparam int HI = bcs_pkg::FIX_LOG2;

    logic             page_c;
    logic             prev_vld;
    logic             prev_start;
    logic [COL_W-1:0] prev_col;
    logic             cont;

    // purpose: remember the kind of burst and the previous beat, independently of the design
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_c     <= 1'b0;
            prev_vld   <= 1'b0;
            prev_start <= 1'b0;
            prev_col   <= '0;
        end else begin
            if (start_i) page_c <= (bl_code_i == bcs_pkg::LEN_PAGE);
            prev_vld   <= beat_vld_o;
            prev_start <= start_i;
            prev_col   <= col_o;
        end
    end

    // purpose: this beat continues the burst of the previous beat
    always_comb cont = beat_vld_o && prev_vld && !prev_start;

    p_beat0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> beat_vld_o && col_o == $past(start_col_i));

    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cont && !page_c |-> col_o[COL_W-1:HI] == prev_col[COL_W-1:HI]);

    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cont && page_c |-> col_o == COL_W'(prev_col + 1'b1));

    p_stop_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && stop_i && !start_i |=> !beat_vld_o && done_o);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !beat_vld_o);

    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && start_i |=> beat_vld_o && !done_o);

    p_idle_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o && stop_i && !start_i |=> !beat_vld_o && !done_o);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> col_o == '0);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .CODE_W(CODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .bl_code_i   (bl_code_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .done_o      (done_o)
);

// File: tb/burst_col_seq_tb_top.sv
// Scoreboard bench: the driver applies one input set per cycle and queues the
// expected outputs; the monitor compares them after each rising edge.
module burst_col_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       ilv_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       vld;
        logic [7:0] col;
        logic       done;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model of the burst, built from the requirements
    bit       m_act = 0;
    int       m_cnt = 0;
    int       m_len = 1;
    bit       m_page = 0;
    bit       m_ilv = 0;
    bit [7:0] m_base = 0;
    bit       m_done = 0;

    always #5 clk = ~clk;

    burst_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .start_col_i(start_col_i), .bl_code_i(bl_code_i), .ilv_i(ilv_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .done_o(done_o)
    );

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] model_col();
        bit [7:0] m;
        bit [7:0] i;
        if (!m_act) return 8'h00;
        i = 8'(m_cnt);
        if (m_page) return m_base + i;
        m = 8'(m_len - 1);
        if (m_ilv) return (m_base & ~m) | ((m_base ^ i) & m);
        return (m_base & ~m) | ((m_base + i) & m);
    endfunction

    task automatic check(input string tag, input logic [7:0] a_col, input logic a_v,
                         input logic a_d, input logic [7:0] e_col, input logic e_v,
                         input logic e_d);
        checks++;
        if (a_col !== e_col || a_v !== e_v || a_d !== e_d) begin
            failures++;
            $display("FAIL %s: actual col=%02h vld=%b done=%b expected col=%02h vld=%b done=%b",
                     tag, a_col, a_v, a_d, e_col, e_v, e_d);
        end
    endtask

    // one cycle of stimulus with the expected result of the following edge
    task automatic step(input bit st, input bit sp, input logic [7:0] col,
                        input logic [2:0] code, input bit il, input string tag);
        exp_t e;
        @(negedge clk);
        start_i = st; stop_i = sp; start_col_i = col; bl_code_i = code; ilv_i = il;
        if (st) begin
            m_act = 1; m_cnt = 0; m_base = col; m_page = (code == 3'b111);
            m_len = len_of(code); m_ilv = il && !m_page; m_done = 0;
        end else if (m_act && (sp || (!m_page && m_cnt == m_len - 1))) begin
            m_act = 0; m_cnt = 0; m_done = 1;
        end else begin
            m_done = 0;
            if (m_act) m_cnt++;
        end
        e.vld = m_act; e.col = model_col(); e.done = m_done; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 8'h00, 3'b000, 0, tag);
    endtask

    task automatic burst(input logic [7:0] col, input logic [2:0] code, input bit il,
                         input string tag);
        step(1, 0, col, code, il, tag);
        idle(len_of(code) + 2, tag);
    endtask

    // monitor: compare after each edge, away from the edge itself
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.tag, col_o, beat_vld_o, done_o, e.col, e.vld, e.done);
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", col_o, beat_vld_o, done_o, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(2, "R1 idle");
        // R3 lengths, R4 sequential wrap inside the aligned block
        burst(8'h5A, 3'b000, 0, "R3 len1");
        burst(8'h11, 3'b001, 0, "R4 len2 seq");
        burst(8'h0E, 3'b010, 0, "R4 len4 seq");
        burst(8'h0D, 3'b010, 0, "R4 len4 seq 0D");
        burst(8'h35, 3'b011, 0, "R4 len8 seq");
        // R5 interleave
        burst(8'h0D, 3'b010, 1, "R5 len4 ilv");
        burst(8'h35, 3'b011, 1, "R5 len8 ilv");
        burst(8'hC3, 3'b001, 1, "R5 len2 ilv");
        // R3 unused codes act as one beat
        burst(8'h77, 3'b100, 0, "R3 code100");
        burst(8'h78, 3'b101, 1, "R3 code101");
        burst(8'h79, 3'b110, 0, "R3 code110");
        // R6 page burst, ilv ignored, runs past 256 beats, then R7/R8 stop
        step(1, 0, 8'hFE, 3'b111, 1, "R6 page start");
        idle(300, "R6 page run");
        step(0, 1, 8'h00, 3'b000, 0, "R7 page stop");
        idle(3, "R8 after page");
        // R7 stop a fixed burst early
        step(1, 0, 8'h42, 3'b011, 0, "R7 len8 start");
        idle(2, "R7 len8 beats");
        step(0, 1, 8'h00, 3'b000, 0, "R7 len8 stop");
        idle(3, "R7 after stop");
        // R9 restart in mid burst, then start with stop at the same edge
        step(1, 0, 8'h20, 3'b011, 1, "R9 first");
        idle(3, "R9 first beats");
        step(1, 0, 8'h93, 3'b010, 0, "R9 restart");
        idle(1, "R9 new beats");
        step(1, 1, 8'h60, 3'b001, 0, "R9 start over stop");
        idle(4, "R9 tail");
        // R9 restart exactly at the edge after the last beat: no done
        step(1, 0, 8'h04, 3'b001, 0, "R9 edge a");
        step(0, 0, 8'h00, 3'b000, 0, "R9 edge beat");
        step(1, 0, 8'h09, 3'b000, 0, "R9 edge b");
        idle(3, "R9 edge tail");
        // R10 stop while idle
        step(0, 1, 8'h00, 3'b000, 0, "R10 idle stop");
        step(0, 1, 8'hFF, 3'b111, 1, "R10 idle stop 2");
        idle(3, "R10 after");
        // R2 back to back bursts
        step(1, 0, 8'hAA, 3'b000, 0, "R2 b2b a");
        step(1, 0, 8'hBB, 3'b001, 1, "R2 b2b b");
        idle(4, "R2 b2b tail");
        wait (exp_q.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule